// File: doc/BRIEF.md
# Dual-Port Burst Static Memory

This block is a two-port word memory in which ports A and B act independently. In any cycle either port may read or write any word, including the word the other port is using. Every input of a port is captured on the rising clock edge: chip selects, read/write, lane enables, address, write data and the burst controls. A port takes part in a cycle only when its active-low select is low and its active-high select is high at that edge. The two selects let several devices share one address space when depth is expanded.

Each port keeps its word address in a burst counter. The counter can be loaded from the address pins, stepped by one with wrap-around, held, or cleared, so streams of consecutive words need only one address load. A shared latency input chooses how read data reaches the pins. In flow-through, data appears in the cycle after the request is captured. In pipelined mode, data passes through one more register and appears one cycle later. Each port's read output is gated by its own active-low output enable, and a valid flag travels with the data.

Top module: `dual_port_burst_ram`

## Requirements
- R1: A port performs a read or write only when, at the capturing edge, its active-low select is 0 and its active-high select is 1. Every other select combination leaves memory and that port's read output untouched.
- R2: With `flow_sel` = 1, data for a read captured at edge N is on the port output after edge N, before edge N+1.
- R3: With `flow_sel` = 0, data for a read captured at edge N is on the port output after edge N+1.
- R4: A low `*_load_n` at an edge loads the pin address into the burst counter, and the access in that cycle uses the loaded address.
- R5: When `*_load_n` is high and `*_step_n` is low, the counter advances by one and wraps from the last word to word 0. With both high, it holds.
- R6: A low `*_zero_n` clears the counter to 0 and takes priority over load and step. The counter updates whether or not the port is selected.
- R7: `*_wr_n` = 0 selects write and 1 selects read. On a write, lane i (bits i*DATA_W/LANES upward) changes only when `*_lane_n[i]` is 0.
- R8: Ports access memory concurrently. A read of a word that the other port writes in the same cycle returns the old contents. When both ports write the same word, port A's enabled lanes win.
- R9: With `*_oe_n` = 1, the port's `dout` is 0 and `dvld` is 0. With 0, `dvld` is 1 and `dout` carries read data. After reset, the output register is 0 and the counter is 0.
- R10: Across write, idle and deselected cycles, a port's output keeps the value of its most recent read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| flow_sel | input | 1 | 1 selects flow-through, 0 selects pipelined |
| a_ce_lo_n | input | 1 | Port A active-low select |
| a_ce_hi | input | 1 | Port A active-high select |
| a_wr_n | input | 1 | Port A 0 = write, 1 = read |
| a_lane_n | input | LANES | Port A active-low lane write enables |
| a_addr | input | ADDR_W | Port A address for counter load |
| a_wdata | input | DATA_W | Port A write data |
| a_load_n | input | 1 | Port A counter load, active low |
| a_step_n | input | 1 | Port A counter increment, active low |
| a_zero_n | input | 1 | Port A counter clear, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_dout | output | DATA_W | Port A read data |
| a_dvld | output | 1 | Port A read data valid |
| b_ce_lo_n | input | 1 | Port B active-low select |
| b_ce_hi | input | 1 | Port B active-high select |
| b_wr_n | input | 1 | Port B 0 = write, 1 = read |
| b_lane_n | input | LANES | Port B active-low lane write enables |
| b_addr | input | ADDR_W | Port B address for counter load |
| b_wdata | input | DATA_W | Port B write data |
| b_load_n | input | 1 | Port B counter load, active low |
| b_step_n | input | 1 | Port B counter increment, active low |
| b_zero_n | input | 1 | Port B counter clear, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_dout | output | DATA_W | Port B read data |
| b_dvld | output | 1 | Port B read data valid |

## Verification
A counter that slips by one word shows up at the first read of a burst. In flow-through that is the cycle after capture, and in pipelined mode it is one cycle later. A lane enable or collision rule that is wrong leaves a corrupted word in memory. That word stays hidden until some port reads it back, so the bench reads each written word soon after it is written and uses random bursts over a small address window, which makes collisions frequent. A stale or wrongly loaded output register breaks the held-value rule on the very next non-read cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int DEF_ADDR_W = 8;
    localparam int DEF_DATA_W = 18;
    localparam int DEF_LANES  = 2;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_LOAD,
        CNT_STEP,
        CNT_ZERO
    } cnt_act_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } port_op_t;

    // Clear beats load, load beats step.
    function automatic cnt_act_t pick_cnt_act(input logic zero_n,
                                              input logic load_n,
                                              input logic step_n);
        if (!zero_n)      return CNT_ZERO;
        else if (!load_n) return CNT_LOAD;
        else if (!step_n) return CNT_STEP;
        return CNT_HOLD;
    endfunction

    function automatic logic port_selected(input logic ce_lo_n, input logic ce_hi);
        return !ce_lo_n && ce_hi;
    endfunction

endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front
    import dpr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_lo_n,
    input  logic              ce_hi,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              zero_n,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  lane_we_q,
    output port_op_t          op_q
);

    cnt_act_t act;
    logic     sel;

    assign act = pick_cnt_act(zero_n, load_n, step_n);
    assign sel = port_selected(ce_lo_n, ce_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            lane_we_q <= '0;
            op_q      <= '0;
        end else begin
            unique case (act)
                CNT_ZERO: addr_q <= '0;
                CNT_LOAD: addr_q <= addr_in;
                CNT_STEP: addr_q <= addr_q + ADDR_W'(1);
                default:  addr_q <= addr_q;
            endcase
            op_q.rd   <= sel && wr_n;
            op_q.wr   <= sel && !wr_n;
            wdata_q   <= wdata_in;
            lane_we_q <= ~lane_n;
        end
    end

    // R1
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        !(ce_lo_n == 1'b0 && ce_hi == 1'b1) |=> (op_q == '0));

    // R6
    counter_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !zero_n |=> (addr_q == '0));

    // R4
    counter_load_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_n && !load_n) |=> (addr_q == $past(addr_in)));

    // R5
    counter_step_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_n && load_n && !step_n) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

endmodule

// File: rtl/dpr_core.sv
module dpr_core
    import dpr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    input  logic [LANES-1:0]  we_a,
    input  logic              wr_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    input  logic [LANES-1:0]  we_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    localparam int WORDS = 1 << ADDR_W;
    localparam int LW    = DATA_W / LANES;

    logic [DATA_W-1:0] mem [WORDS];

    // Port B first so port A's lanes land last on a shared word.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_b && we_b[l]) mem[addr_b][l*LW +: LW] <= wdata_b[l*LW +: LW];
            if (wr_a && we_a[l]) mem[addr_a][l*LW +: LW] <= wdata_a[l*LW +: LW];
        end
    end

    assign rdata_a = mem[addr_a];
    assign rdata_b = mem[addr_b];

    // R7
    lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_a && !we_a[0] && !(wr_b && addr_b == addr_a))
        |=> (mem[$past(addr_a)][LW-1:0] == $past(rdata_a[LW-1:0])));

    // R8
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_a && wr_b && addr_a == addr_b && (&we_a))
        |=> (mem[$past(addr_a)] == $past(wdata_a)));

endmodule

// File: rtl/dpr_out.sv
module dpr_out
    import dpr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flow_sel,
    input  logic              oe_n,
    input  logic              rd_q,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              dvld
);

    logic [DATA_W-1:0] pipe_q;
    logic [DATA_W-1:0] view;

    always_ff @(posedge clk) begin
        if (rst)       pipe_q <= '0;
        else if (rd_q) pipe_q <= rdata;
    end

    assign view = (flow_sel && rd_q) ? rdata : pipe_q;
    assign dout = oe_n ? '0 : view;
    assign dvld = !oe_n;

    // R3
    pipe_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_q && !flow_sel && !oe_n)
        |=> (flow_sel || oe_n || dout == $past(rdata)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_q && !oe_n && !flow_sel) |=> (flow_sel || oe_n || rd_q || $stable(dout)));

endmodule

// File: rtl/dual_port_burst_ram.sv
module dual_port_burst_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flow_sel,
    input  logic              a_ce_lo_n,
    input  logic              a_ce_hi,
    input  logic              a_wr_n,
    input  logic [LANES-1:0]  a_lane_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_load_n,
    input  logic              a_step_n,
    input  logic              a_zero_n,
    input  logic              a_oe_n,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_dvld,
    input  logic              b_ce_lo_n,
    input  logic              b_ce_hi,
    input  logic              b_wr_n,
    input  logic [LANES-1:0]  b_lane_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_load_n,
    input  logic              b_step_n,
    input  logic              b_zero_n,
    input  logic              b_oe_n,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_dvld
);

    logic [ADDR_W-1:0] addr_qa, addr_qb;
    logic [DATA_W-1:0] wdata_qa, wdata_qb;
    logic [LANES-1:0]  we_qa, we_qb;
    port_op_t          op_qa, op_qb;
    logic [DATA_W-1:0] rdata_a, rdata_b;

    dpr_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_front_a (
        .clk(clk), .rst(rst), .ce_lo_n(a_ce_lo_n), .ce_hi(a_ce_hi), .wr_n(a_wr_n),
        .lane_n(a_lane_n), .addr_in(a_addr), .wdata_in(a_wdata), .load_n(a_load_n),
        .step_n(a_step_n), .zero_n(a_zero_n), .addr_q(addr_qa), .wdata_q(wdata_qa),
        .lane_we_q(we_qa), .op_q(op_qa)
    );

    dpr_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_front_b (
        .clk(clk), .rst(rst), .ce_lo_n(b_ce_lo_n), .ce_hi(b_ce_hi), .wr_n(b_wr_n),
        .lane_n(b_lane_n), .addr_in(b_addr), .wdata_in(b_wdata), .load_n(b_load_n),
        .step_n(b_step_n), .zero_n(b_zero_n), .addr_q(addr_qb), .wdata_q(wdata_qb),
        .lane_we_q(we_qb), .op_q(op_qb)
    );

    dpr_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_core (
        .clk(clk), .rst(rst),
        .wr_a(op_qa.wr), .addr_a(addr_qa), .wdata_a(wdata_qa), .we_a(we_qa),
        .wr_b(op_qb.wr), .addr_b(addr_qb), .wdata_b(wdata_qb), .we_b(we_qb),
        .rdata_a(rdata_a), .rdata_b(rdata_b)
    );

    dpr_out #(.DATA_W(DATA_W)) u_out_a (
        .clk(clk), .rst(rst), .flow_sel(flow_sel), .oe_n(a_oe_n), .rd_q(op_qa.rd),
        .rdata(rdata_a), .dout(a_dout), .dvld(a_dvld)
    );

    dpr_out #(.DATA_W(DATA_W)) u_out_b (
        .clk(clk), .rst(rst), .flow_sel(flow_sel), .oe_n(b_oe_n), .rd_q(op_qb.rd),
        .rdata(rdata_b), .dout(b_dout), .dvld(b_dvld)
    );

endmodule

// File: tb/test_dual_port_burst_ram.sv
module test_dual_port_burst_ram;

    localparam int AW    = 8;
    localparam int DW    = 18;
    localparam int LN    = 2;
    localparam int WORDS = 1 << AW;
    localparam int LW    = DW / LN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flow_sel = 1'b1;

    logic          ce_lo_n [2];
    logic          ce_hi   [2];
    logic          wr_n    [2];
    logic [LN-1:0] lane_n  [2];
    logic [AW-1:0] addr    [2];
    logic [DW-1:0] wdata   [2];
    logic          load_n  [2];
    logic          step_n  [2];
    logic          zero_n  [2];
    logic          oe_n    [2];
    logic [DW-1:0] dout    [2];
    logic          dvld    [2];

    logic [DW-1:0] ref_mem  [WORDS];
    logic [AW-1:0] ref_addr [2];
    logic [DW-1:0] ref_last [2];

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string cur_tag = "R9";

    always #4ns clk = ~clk;

    dual_port_burst_ram #(.ADDR_W(AW), .DATA_W(DW), .LANES(LN)) i_dual_port_burst_ram (
        .clk(clk), .rst(rst), .flow_sel(flow_sel),
        .a_ce_lo_n(ce_lo_n[0]), .a_ce_hi(ce_hi[0]), .a_wr_n(wr_n[0]), .a_lane_n(lane_n[0]),
        .a_addr(addr[0]), .a_wdata(wdata[0]), .a_load_n(load_n[0]), .a_step_n(step_n[0]),
        .a_zero_n(zero_n[0]), .a_oe_n(oe_n[0]), .a_dout(dout[0]), .a_dvld(dvld[0]),
        .b_ce_lo_n(ce_lo_n[1]), .b_ce_hi(ce_hi[1]), .b_wr_n(wr_n[1]), .b_lane_n(lane_n[1]),
        .b_addr(addr[1]), .b_wdata(wdata[1]), .b_load_n(load_n[1]), .b_step_n(step_n[1]),
        .b_zero_n(zero_n[1]), .b_oe_n(oe_n[1]), .b_dout(dout[1]), .b_dvld(dvld[1])
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fill_val(input int i);
        return DW'(i * 37 + 5);
    endfunction

    task automatic drv(input int p, input bit sel, input bit wr, input bit ld, input bit stp,
                       input bit zr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [LN-1:0] ln);
        ce_lo_n[p] = !sel;
        ce_hi[p]   = sel;
        wr_n[p]    = !wr;
        lane_n[p]  = ln;
        addr[p]    = a;
        wdata[p]   = d;
        load_n[p]  = !ld;
        step_n[p]  = !stp;
        zero_n[p]  = !zr;
        oe_n[p]    = 1'b0;
    endtask

    task automatic idle(input int p);
        drv(p, 0, 0, 0, 0, 0, '0, '0, '1);
    endtask

    // One clock: advance the model with the inputs currently driven, then compare.
    task automatic tick();
        logic [DW-1:0] prev [2];
        logic [DW-1:0] exp_d;
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            prev[p] = ref_last[p];
            if (!zero_n[p])      ref_addr[p] = '0;
            else if (!load_n[p]) ref_addr[p] = addr[p];
            else if (!step_n[p]) ref_addr[p] = ref_addr[p] + AW'(1);
        end
        for (int p = 0; p < 2; p++)
            if (!ce_lo_n[p] && ce_hi[p] && wr_n[p]) ref_last[p] = ref_mem[ref_addr[p]];
        for (int p = 1; p >= 0; p--)
            if (!ce_lo_n[p] && ce_hi[p] && !wr_n[p])
                for (int l = 0; l < LN; l++)
                    if (!lane_n[p][l])
                        ref_mem[ref_addr[p]][l*LW +: LW] = wdata[p][l*LW +: LW];
        for (int p = 0; p < 2; p++) begin
            exp_d = oe_n[p] ? '0 : (flow_sel ? ref_last[p] : prev[p]);
            chk(cur_tag, dout[p], exp_d);
            chk(oe_n[p] ? "R9 valid low" : "R9 valid high", DW'(dvld[p]), DW'(!oe_n[p]));
        end
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
        ref_addr[0] = '0; ref_addr[1] = '0;
        ref_last[0] = '0; ref_last[1] = '0;
        idle(0); idle(1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state of the outputs
        chk("R9 reset dout a", dout[0], '0);
        chk("R9 reset dout b", dout[1], '0);

        // R4 / R5: burst fill of the array from port A, then a wrap write to word 0
        cur_tag = "R4";
        drv(0, 1, 1, 1, 0, 0, '0, fill_val(0), 2'b00); tick();
        cur_tag = "R5";
        for (int i = 1; i < WORDS; i++) begin
            drv(0, 1, 1, 0, 1, 0, '0, fill_val(i), 2'b00); tick();
        end
        drv(0, 1, 1, 0, 1, 0, '0, DW'(18'h2A5A5), 2'b00); tick();
        idle(0);
        drv(1, 1, 0, 1, 0, 0, '0, '0, '1); tick();
        drv(1, 1, 0, 0, 1, 0, '0, '0, '1); tick();

        // R6: clear wins over a simultaneous load
        cur_tag = "R6";
        drv(1, 1, 0, 1, 0, 1, 8'd5, '0, '1); tick();
        drv(1, 1, 0, 0, 1, 0, '0, '0, '1); tick();

        // R1: both deselecting combinations block a write
        cur_tag = "R1";
        idle(1);
        drv(0, 1, 1, 1, 0, 0, 8'd9, DW'(18'h11111), 2'b00);
        ce_lo_n[0] = 1'b1; ce_hi[0] = 1'b1; tick();
        drv(0, 1, 1, 1, 0, 0, 8'd9, DW'(18'h22222), 2'b00);
        ce_lo_n[0] = 1'b0; ce_hi[0] = 1'b0; tick();
        idle(0);
        drv(1, 1, 0, 1, 0, 0, 8'd9, '0, '1); tick();

        // R7: only lane 0 written
        cur_tag = "R7";
        idle(1);
        drv(0, 1, 1, 1, 0, 0, 8'd10, DW'(18'h3FFFF), 2'b10); tick();
        drv(0, 1, 0, 1, 0, 0, 8'd10, '0, '1); tick();
        drv(0, 1, 1, 1, 0, 0, 8'd10, DW'(18'h00000), 2'b01); tick();
        drv(0, 1, 0, 1, 0, 0, 8'd10, '0, '1); tick();

        // R8: read of a word under write by the other port, and a double write
        cur_tag = "R8";
        drv(0, 1, 1, 1, 0, 0, 8'd11, DW'(18'h0BEEF), 2'b00);
        drv(1, 1, 0, 1, 0, 0, 8'd11, '0, '1); tick();
        drv(0, 1, 0, 1, 0, 0, 8'd11, '0, '1); tick();
        drv(0, 1, 1, 1, 0, 0, 8'd12, DW'(18'h0AAAA), 2'b00);
        drv(1, 1, 1, 1, 0, 0, 8'd12, DW'(18'h15555), 2'b00); tick();
        drv(0, 1, 0, 1, 0, 0, 8'd12, '0, '1);
        drv(1, 1, 0, 1, 0, 0, 8'd12, '0, '1); tick();

        // R10: output holds across writes and deselected cycles
        cur_tag = "R10";
        drv(1, 1, 0, 1, 0, 0, 8'd3, '0, '1); tick();
        drv(1, 1, 1, 1, 0, 0, 8'd4, DW'(18'h01234), 2'b00); tick();
        idle(1); tick(); tick();

        // R9: output enable off then on
        cur_tag = "R9";
        drv(0, 1, 0, 1, 0, 0, 8'd7, '0, '1); oe_n[0] = 1'b1; tick();
        oe_n[0] = 1'b0; idle(1); tick();

        // R3: pipelined mode, directed reads
        cur_tag = "R3";
        flow_sel = 1'b0;
        drv(0, 1, 0, 1, 0, 0, 8'd20, '0, '1); tick();
        drv(0, 1, 0, 0, 1, 0, '0, '0, '1); tick();
        drv(0, 1, 1, 0, 1, 0, '0, DW'(18'h3C3C3), 2'b00); tick();
        idle(0); tick(); tick();

        // Random traffic over a small window, switching latency mode in segments
        for (int seg = 0; seg < 16; seg++) begin
            flow_sel = seg[0];
            cur_tag  = flow_sel ? "R2" : "R3";
            for (int c = 0; c < 200; c++) begin
                for (int p = 0; p < 2; p++) begin
                    drv(p, ($urandom % 10) != 0, $urandom % 2, ($urandom % 10) < 3,
                        $urandom % 2, ($urandom % 32) == 0, AW'($urandom % 16),
                        DW'($urandom), LN'($urandom));
                    oe_n[p] = (($urandom % 10) == 0);
                end
                tick();
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule